// File: doc/BRIEF.md
# Synthesizer Serial Control Register Bank

This block stores the programming words of a two-loop frequency synthesizer and turns the global control bits into steady control lines for the rest of the chip. A word enters one bit per clock through a serial shift path. A rising edge on a separate latch strobe then copies the word's upper bits into one of seven registers. The three lowest bits of that same word choose the register.

The divider and control words for the RF loop and the IF loop are brought out unchanged. The master register is decoded into the following lines: a power-down line, a counter hold, a charge-pump high-impedance line, a reference-oscillator disable and a four-bit output-multiplexer select. A one-cycle new-channel pulse follows every write to either N divider, and the lock detector uses it as a clear.

A write to either loop's control register marks the multiplexer setting as stale. It stays stale until the master register is written again. Power-down forces the counter hold, the charge-pump high-impedance line and the lock-detector clear. It does not touch the stored words, and writes are still accepted while it is active.

Top module: `synth_ctl_bank`

## Requirements
- R1: While `sh_en` is high at a rising `clk` edge, `sh_data` enters the shift word at bit 0 and earlier bits move up one place. The first bit shifted in therefore ends at bit WORD_W-1 (MSB first).
- R2: When `le` is first seen high at a rising edge, bits [WORD_W-1:3] of the shift word go into the register whose address is in bits [2:0]. The addresses are: 0 = RF N, 1 = RF R, 2 = RF control, 3 = master, 4 = IF N, 5 = IF R, 6 = IF control. The outputs show the new value after that same edge, and address 7 changes no output.
- R3: `le` staying high for further cycles causes no further write, even if the shift word changes. A new write needs `le` to go low and then high again.
- R4: Payload bit 0 of the master register is power-down, and it drives `pwr_dn`. While it is 1, `cnt_hold`, `cp_hiz` and `lock_clr` are all high.
- R5: Power-down leaves every stored word unchanged, and words written while it is active are stored normally.
- R6: Master payload bit 1 is counter reset. When it is 1, `cnt_hold` is high.
- R7: Master payload bit 2 is charge-pump three-state. When it is 1, `cp_hiz` is high.
- R8: Master payload bit 3 drives `ref_osc_off` directly.
- R9: `mux_vld` goes high after a master write and low after a write to address 2 or 6. `mux_sel` shows master payload bits [7:4] while `mux_vld` is high and reads 0 otherwise.
- R10: A write to address 0 or 4 makes `new_chan` high for exactly the one cycle after the latch edge. `lock_clr` is high whenever `new_chan` is high.
- R11: After a synchronous reset (`rst` high at a clock edge), all stored words and all control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sh_en | input | 1 | Shift enable for the serial word |
| sh_data | input | 1 | Serial data bit, MSB first |
| le | input | 1 | Latch strobe, acts on its rising edge |
| rf_n | output | WORD_W-3 | RF N divider word |
| rf_r | output | WORD_W-3 | RF R divider word |
| rf_ctl | output | WORD_W-3 | RF control word |
| mst_word | output | WORD_W-3 | Master register word |
| if_n | output | WORD_W-3 | IF N divider word |
| if_r | output | WORD_W-3 | IF R divider word |
| if_ctl | output | WORD_W-3 | IF control word |
| pwr_dn | output | 1 | Power-down active |
| cnt_hold | output | 1 | Hold all divider counters in their load state |
| cp_hiz | output | 1 | Both charge pumps to high impedance |
| lock_clr | output | 1 | Clear for the lock detector |
| ref_osc_off | output | 1 | Reference oscillator disable |
| mux_sel | output | 4 | Output multiplexer select, 0 while stale |
| mux_vld | output | 1 | Multiplexer select is current |
| new_chan | output | 1 | One-cycle pulse after an N divider write |

## Verification
The assertions assume that `le` is synchronous to `clk` and that every high pulse of it is separated from the next by at least one low cycle. On that basis, any change of a stored word and any `new_chan` pulse can be traced to a low-then-high step of `le` exactly one sample earlier. The stimulus drives all inputs on the falling clock edge. It keeps `sh_en` low in the cycle where `le` rises, so the latched word is always the complete shifted word. It deliberately holds `le` high across several shift cycles to show that no extra write happens.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int ADDR_W = 3;
  localparam int NREG   = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_RF_N   = 3'd0,
    A_RF_R   = 3'd1,
    A_RF_CTL = 3'd2,
    A_MASTER = 3'd3,
    A_IF_N   = 3'd4,
    A_IF_R   = 3'd5,
    A_IF_CTL = 3'd6,
    A_SPARE  = 3'd7
  } reg_addr_e;

  // master payload field positions
  localparam int PD_BIT   = 0;
  localparam int CRST_BIT = 1;
  localparam int TRI_BIT  = 2;
  localparam int OSC_BIT  = 3;
  localparam int MUX_LSB  = 4;
  localparam int MUX_W    = 4;
  localparam int MST_USED = MUX_LSB + MUX_W;
endpackage

// File: rtl/ctl_shift.sv
module ctl_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sh_en,
  input  logic              sh_data,
  input  logic              le,
  output logic [WORD_W-1:0] word,
  output logic              wr_stb
);
  logic le_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      le_q <= 1'b0;
    end else begin
      le_q <= le;
      if (sh_en) word <= {word[WORD_W-2:0], sh_data};
    end
  end

  // write fires on the first cycle le is seen high
  assign wr_stb = le & ~le_q;
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import synth_ctl_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int PAY_W = WORD_W - ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_stb,
  input  logic [WORD_W-1:0]          word,
  output logic [NREG-1:0][PAY_W-1:0] q
);
  logic [ADDR_W-1:0] addr;
  assign addr = word[ADDR_W-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q[g] <= '0;
      else if (wr_stb && addr == ADDR_W'(g)) q[g] <= word[WORD_W-1:ADDR_W];
    end
  end
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import synth_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [MST_USED-1:0] mst,
  output logic                pwr_dn,
  output logic                cnt_hold,
  output logic                cp_hiz,
  output logic                lock_clr,
  output logic                ref_osc_off,
  output logic [MUX_W-1:0]    mux_sel,
  output logic                mux_vld,
  output logic                new_chan
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mux_vld  <= 1'b0;
      new_chan <= 1'b0;
    end else begin
      new_chan <= wr_stb && (addr == A_RF_N || addr == A_IF_N);
      if (wr_stb) begin
        if (addr == A_MASTER) mux_vld <= 1'b1;
        else if (addr == A_RF_CTL || addr == A_IF_CTL) mux_vld <= 1'b0;
      end
    end
  end

  always_comb begin
    pwr_dn      = mst[PD_BIT];
    cnt_hold    = mst[PD_BIT] | mst[CRST_BIT];
    cp_hiz      = mst[PD_BIT] | mst[TRI_BIT];
    lock_clr    = mst[PD_BIT] | new_chan;
    ref_osc_off = mst[OSC_BIT];
    mux_sel     = mux_vld ? mst[MUX_LSB +: MUX_W] : '0;
  end
endmodule

// File: rtl/synth_ctl_bank.sv
module synth_ctl_bank
  import synth_ctl_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sh_en,
  input  logic              sh_data,
  input  logic              le,
  output logic [WORD_W-4:0] rf_n,
  output logic [WORD_W-4:0] rf_r,
  output logic [WORD_W-4:0] rf_ctl,
  output logic [WORD_W-4:0] mst_word,
  output logic [WORD_W-4:0] if_n,
  output logic [WORD_W-4:0] if_r,
  output logic [WORD_W-4:0] if_ctl,
  output logic              pwr_dn,
  output logic              cnt_hold,
  output logic              cp_hiz,
  output logic              lock_clr,
  output logic              ref_osc_off,
  output logic [3:0]        mux_sel,
  output logic              mux_vld,
  output logic              new_chan
);
  localparam int PAY_W = WORD_W - ADDR_W;

  logic [WORD_W-1:0]          word;
  logic                       wr_stb;
  logic [NREG-1:0][PAY_W-1:0] q;

  ctl_shift #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rst(rst), .sh_en(sh_en), .sh_data(sh_data), .le(le),
    .word(word), .wr_stb(wr_stb)
  );

  ctl_regfile #(.WORD_W(WORD_W)) regs_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .word(word), .q(q)
  );

  ctl_decode dec_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(word[ADDR_W-1:0]),
    .mst(q[A_MASTER][MST_USED-1:0]),
    .pwr_dn(pwr_dn), .cnt_hold(cnt_hold), .cp_hiz(cp_hiz), .lock_clr(lock_clr),
    .ref_osc_off(ref_osc_off), .mux_sel(mux_sel), .mux_vld(mux_vld),
    .new_chan(new_chan)
  );

  assign rf_n     = q[A_RF_N];
  assign rf_r     = q[A_RF_R];
  assign rf_ctl   = q[A_RF_CTL];
  assign mst_word = q[A_MASTER];
  assign if_n     = q[A_IF_N];
  assign if_r     = q[A_IF_R];
  assign if_ctl   = q[A_IF_CTL];
endmodule

// File: rtl/synth_ctl_chk.sv
module synth_ctl_chk #(
  parameter int PAY_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             le,
  input logic [PAY_W-1:0] if_n,
  input logic [PAY_W-1:0] mst_word,
  input logic             pwr_dn,
  input logic             cnt_hold,
  input logic             cp_hiz,
  input logic             lock_clr,
  input logic [3:0]       mux_sel,
  input logic             mux_vld,
  input logic             new_chan
);
  AST_PD_FORCES: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |-> (cnt_hold && cp_hiz && lock_clr)); // R4
  AST_NC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    new_chan |=> !new_chan); // R10
  AST_NC_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    new_chan |-> ($past(le) && !$past(le, 2))); // R10
  AST_WRITE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $changed(if_n) |-> ($past(le) && !$past(le, 2))); // R3
  AST_MST_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $changed(mst_word) |-> ($past(le) && !$past(le, 2))); // R2
  AST_MUX_STALE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mux_vld |-> (mux_sel == 4'd0)); // R9
endmodule

bind synth_ctl_bank synth_ctl_chk #(.PAY_W(WORD_W - 3)) chk_i (
  .clk(clk), .rst(rst), .le(le), .if_n(if_n), .mst_word(mst_word),
  .pwr_dn(pwr_dn), .cnt_hold(cnt_hold), .cp_hiz(cp_hiz), .lock_clr(lock_clr),
  .mux_sel(mux_sel), .mux_vld(mux_vld), .new_chan(new_chan)
);

// File: tb/synth_ctl_bank_tb.sv
module synth_ctl_bank_tb_top;
  localparam int W  = 24;
  localparam int PW = W - 3;

  logic clk = 0, rst = 1, sh_en = 0, sh_data = 0, le = 0;
  logic [PW-1:0] rf_n, rf_r, rf_ctl, mst_word, if_n, if_r, if_ctl;
  logic pwr_dn, cnt_hold, cp_hiz, lock_clr, ref_osc_off, mux_vld, new_chan;
  logic [3:0] mux_sel;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_ctl_bank #(.WORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .sh_en(sh_en), .sh_data(sh_data), .le(le),
    .rf_n(rf_n), .rf_r(rf_r), .rf_ctl(rf_ctl), .mst_word(mst_word),
    .if_n(if_n), .if_r(if_r), .if_ctl(if_ctl), .pwr_dn(pwr_dn),
    .cnt_hold(cnt_hold), .cp_hiz(cp_hiz), .lock_clr(lock_clr),
    .ref_osc_off(ref_osc_off), .mux_sel(mux_sel), .mux_vld(mux_vld),
    .new_chan(new_chan)
  );

  // behavioural reference model
  logic [W-1:0]  m_sh;
  logic [PW-1:0] m_reg [8];
  bit m_le, m_mv, m_nc;

  always @(posedge clk) begin
    if (rst) begin
      m_sh = '0; m_le = 0; m_mv = 0; m_nc = 0;
      foreach (m_reg[i]) m_reg[i] = '0;
    end else begin
      m_nc = 0;
      if (le && !m_le) begin
        int a;
        a = int'(m_sh[2:0]);
        m_reg[a] = m_sh[W-1:3];
        if (a == 3) m_mv = 1;
        if (a == 2 || a == 6) m_mv = 0;
        if (a == 0 || a == 4) m_nc = 1;
      end
      if (sh_en) m_sh = {m_sh[W-2:0], sh_data};
      m_le = le;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit pd;
      pd = m_reg[3][0];
      chk("R2", "rf_n", 64'(rf_n), 64'(m_reg[0]));
      chk("R2", "rf_r", 64'(rf_r), 64'(m_reg[1]));
      chk("R2", "rf_ctl", 64'(rf_ctl), 64'(m_reg[2]));
      chk("R2", "mst_word", 64'(mst_word), 64'(m_reg[3]));
      chk("R5", "if_n", 64'(if_n), 64'(m_reg[4]));
      chk("R5", "if_r", 64'(if_r), 64'(m_reg[5]));
      chk("R2", "if_ctl", 64'(if_ctl), 64'(m_reg[6]));
      chk("R4", "pwr_dn", 64'(pwr_dn), 64'(pd));
      chk("R6", "cnt_hold", 64'(cnt_hold), 64'(pd | m_reg[3][1]));
      chk("R7", "cp_hiz", 64'(cp_hiz), 64'(pd | m_reg[3][2]));
      chk("R8", "ref_osc_off", 64'(ref_osc_off), 64'(m_reg[3][3]));
      chk("R9", "mux_vld", 64'(mux_vld), 64'(m_mv));
      chk("R9", "mux_sel", 64'(mux_sel), 64'(m_mv ? m_reg[3][7:4] : 4'd0));
      chk("R10", "new_chan", 64'(new_chan), 64'(m_nc));
      chk("R10", "lock_clr", 64'(lock_clr), 64'(pd | m_nc));
    end
  end

  function automatic logic [W-1:0] mk(input int a, input logic [PW-1:0] p);
    return {p, 3'(a)};
  endfunction

  task automatic shift_in(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk); sh_en = 1; sh_data = w[i];
    end
    @(negedge clk); sh_en = 0; sh_data = 0;
  endtask

  task automatic write(input logic [W-1:0] w);
    shift_in(w);
    le = 1;
    @(negedge clk); le = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "if_n after reset", 64'(if_n), 0);
    chk("R11", "mux_vld after reset", 64'(mux_vld), 0);
    rst = 0;
    @(negedge clk);
    chk("R11", "cnt_hold after reset", 64'(cnt_hold), 0);
    // master: mux 5, counter reset
    write(mk(3, PW'('h52)));
    chk("R9", "mux_sel directed", 64'(mux_sel), 5);
    chk("R6", "cnt_hold directed", 64'(cnt_hold), 1);
    write(mk(4, PW'('h1234)));   // R10 new channel
    write(mk(0, PW'('h0abc)));   // R10 RF N
    chk("R1", "rf_n MSB-first", 64'(rf_n), 64'('h0abc));
    write(mk(2, PW'('h77)));     // R9 stale
    chk("R9", "mux_sel stale", 64'(mux_sel), 0);
    write(mk(3, PW'('h9d)));     // R4 power-down, osc off, mux 9
    chk("R4", "pwr_dn directed", 64'(pwr_dn), 1);
    write(mk(5, PW'('h4321)));   // R5 write during power-down
    chk("R5", "if_n kept", 64'(if_n), 64'('h1234));
    chk("R5", "if_r during pd", 64'(if_r), 64'('h4321));
    write(mk(7, PW'('h1fffff))); // R2 spare address
    write(mk(6, PW'('h3)));      // R9 IF control stale
    // R3: le held high while another word shifts in
    shift_in(mk(4, PW'('h0055)));
    le = 1;
    shift_in(mk(5, PW'('h0aaa)));
    repeat (3) @(negedge clk);
    chk("R3", "if_r no relatch", 64'(if_r), 64'('h4321));
    le = 0;
    @(negedge clk);
    write(mk(3, PW'('h0)));
    write(mk(1, PW'('h1fffff)));
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule